// File: doc/BRIEF.md
# Ternary Ingress Packet Filter Table

This block holds a small table of packet classification rules and compares the header key of every ingress packet against all of them in a single lookup. Each rule stores a value and a mask for every header field. It also stores an address-family bit and an action descriptor. The action descriptor holds the disposition (pass, drop or loop back out as egress), a steering choice and a receive queue number. A field agrees with a rule when the packet bits under the mask equal the stored value. A rule hits only when every field agrees and the address family is the same.

Control software loads or removes a rule at any of the 16 slots through a simple write port. It also programs a global select register. That register decides which of the optional compact header fields (ports, VLANs, function identifiers and similar) take part in matching for every rule at once. The address and port fields of the flow always take part. The datapath presents a valid-qualified key. One clock later the block reports whether any rule hit, the index of the winning rule, and that rule's disposition and steering.

Top module: `pkt_flt_table`

## Requirements
- R1: A rule field agrees with the packet when (packet AND mask) equals value, for every field, and partial masks are legal. A rule with value 0 and mask 0 on a field accepts any packet value there. A rule hits only if all its fields agree.
- R2: Each rule's address-family bit (0 = IPv4, 1 = IPv6) must equal the packet's `lk_v6` exactly. No mask applies to it.
- R3: The optional compact fields join the comparison only when their bit in the select register is set. Bit 0 = ingress port (3), 1 = protocol (8), 2 = TOS (8), 3 = ethertype (16), 4 = fragment (1), 5 = FCoE (1), 6 = MAC index (9), 7 = match type (3), 8 = inner VLAN (16, with its valid flag), 9 = outer VLAN (16, with its valid flag), 10 = PF (8), 11 = VF (8). The PF/VF valid flag joins when bit 10 or bit 11 is set.
- R4: A select write whose selected widths add to more than 36 bits is rejected, and the previous selection stays in force. A total of exactly 36 bits is accepted.
- R5: When several rules hit, the lowest index wins.
- R6: On a miss with `lk_valid` set, `res_hit` = 0, `res_idx` = 0, `res_action` = 0 (pass), `res_steer` = 0 and `res_queue` = 0.
- R7: The result appears on the clock edge after `lk_valid` is sampled, and `res_valid` marks it. In cycles without a result, `res_hit` is 0.
- R8: A rule write takes effect for lookups presented in the following cycle. A lookup presented in the same cycle as the write sees the old contents.
- R9: A write with `wr_del` = 1 invalidates the entry at `wr_idx`.
- R10: Action code 3 is reserved. A non-delete write that carries it leaves the entry unchanged.
- R11: Action codes are 0 = pass, 1 = drop and 2 = switch. On a hit, `res_steer` equals the rule's steer bit. `res_queue` equals the rule's 10-bit queue when the steer bit is 1, and is 0 when it is 0 (hash distribution).
- R12: After reset every entry is invalid and the select register is 0, so no compact field takes part.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_wr_en | input | 1 | Write strobe for the field select register |
| sel_wr_data | input | 12 | New field selection (bit map per R3) |
| wr_en | input | 1 | Rule write strobe |
| wr_del | input | 1 | 1 = invalidate the slot, 0 = load a rule |
| wr_idx | input | 4 | Slot index |
| wr_v6 | input | 1 | Rule address family |
| wr_val | input | KEY_W | Rule value key (layout `key_t`) |
| wr_msk | input | KEY_W | Rule mask key (layout `key_t`) |
| wr_action | input | 2 | Disposition code |
| wr_steer | input | 1 | 1 = direct queue, 0 = hash distribution |
| wr_queue | input | 10 | Direct receive queue |
| lk_valid | input | 1 | Lookup request |
| lk_v6 | input | 1 | Packet address family |
| lk_key | input | KEY_W | Packet header key (layout `key_t`) |
| res_valid | output | 1 | Result valid |
| res_hit | output | 1 | Some rule hit |
| res_idx | output | 4 | Winning slot |
| res_action | output | 2 | Winning disposition |
| res_steer | output | 1 | Winning steer bit |
| res_queue | output | 10 | Winning queue, or 0 |

## Verification
A rule update and a lookup can land in the same clock cycle. The bench provokes this by raising `wr_en` and `lk_valid` on the same edge, with a new disposition and queue for a slot that the key already hits. It judges the first result against the old action and the lookup presented one cycle later against the new one. A select-register write is also mixed with lookups, and each accepted or rejected selection is judged by whether a rule on the ingress port field starts or stops filtering.

// File: rtl/pkt_flt_pkg.sv
package pkt_flt_pkg;

    localparam int ADDR_W   = 128;
    localparam int PORT_W   = 16;
    localparam int QID_W    = 10;
    localparam int SEL_W    = 12;
    localparam int CAP_BITS = 36;

    localparam int W_IPORT = 3;
    localparam int W_PROTO = 8;
    localparam int W_TOS   = 8;
    localparam int W_ETH   = 16;
    localparam int W_FRAG  = 1;
    localparam int W_FCOE  = 1;
    localparam int W_MACX  = 9;
    localparam int W_MTYPE = 3;
    localparam int W_VLAN  = 16;
    localparam int W_FN    = 8;

    localparam int SB_IPORT = 0;
    localparam int SB_PROTO = 1;
    localparam int SB_TOS   = 2;
    localparam int SB_ETH   = 3;
    localparam int SB_FRAG  = 4;
    localparam int SB_FCOE  = 5;
    localparam int SB_MACX  = 6;
    localparam int SB_MTYPE = 7;
    localparam int SB_IVLAN = 8;
    localparam int SB_OVLAN = 9;
    localparam int SB_PF    = 10;
    localparam int SB_VF    = 11;

    typedef struct packed {
        logic               ivlan_ok;
        logic               ovlan_ok;
        logic               fn_ok;
        logic [W_IPORT-1:0] iport;
        logic [W_PROTO-1:0] proto;
        logic [W_TOS-1:0]   tos;
        logic [W_ETH-1:0]   eth;
        logic [W_FRAG-1:0]  frag;
        logic [W_FCOE-1:0]  fcoe;
        logic [W_MACX-1:0]  macx;
        logic [W_MTYPE-1:0] mtype;
        logic [W_VLAN-1:0]  ivlan;
        logic [W_VLAN-1:0]  ovlan;
        logic [W_FN-1:0]    pf;
        logic [W_FN-1:0]    vf;
    } ctup_t;

    typedef struct packed {
        logic [ADDR_W-1:0] lip;
        logic [ADDR_W-1:0] fip;
        logic [PORT_W-1:0] lport;
        logic [PORT_W-1:0] fport;
        ctup_t             c;
    } key_t;

    localparam int KEY_W = $bits(key_t);

    typedef enum logic [1:0] {
        ACT_PASS   = 2'd0,
        ACT_DROP   = 2'd1,
        ACT_SWITCH = 2'd2,
        ACT_RSVD   = 2'd3
    } act_e;

    typedef struct packed {
        logic             vld;
        logic             v6;
        key_t             val;
        key_t             msk;
        act_e             act;
        logic             steer;
        logic [QID_W-1:0] queue;
    } rule_t;

    // Total key bits a selection would add.
    function automatic int sel_width(logic [SEL_W-1:0] s);
        int w;
        w = 0;
        if (s[SB_IPORT]) w += W_IPORT;
        if (s[SB_PROTO]) w += W_PROTO;
        if (s[SB_TOS])   w += W_TOS;
        if (s[SB_ETH])   w += W_ETH;
        if (s[SB_FRAG])  w += W_FRAG;
        if (s[SB_FCOE])  w += W_FCOE;
        if (s[SB_MACX])  w += W_MACX;
        if (s[SB_MTYPE]) w += W_MTYPE;
        if (s[SB_IVLAN]) w += W_VLAN;
        if (s[SB_OVLAN]) w += W_VLAN;
        if (s[SB_PF])    w += W_FN;
        if (s[SB_VF])    w += W_FN;
        return w;
    endfunction

    // Bits of the compact tuple that take part under a selection.
    function automatic ctup_t sel_mask(logic [SEL_W-1:0] s);
        ctup_t c;
        c = '0;
        if (s[SB_IPORT]) c.iport = '1;
        if (s[SB_PROTO]) c.proto = '1;
        if (s[SB_TOS])   c.tos   = '1;
        if (s[SB_ETH])   c.eth   = '1;
        if (s[SB_FRAG])  c.frag  = '1;
        if (s[SB_FCOE])  c.fcoe  = '1;
        if (s[SB_MACX])  c.macx  = '1;
        if (s[SB_MTYPE]) c.mtype = '1;
        if (s[SB_IVLAN]) begin
            c.ivlan    = '1;
            c.ivlan_ok = 1'b1;
        end
        if (s[SB_OVLAN]) begin
            c.ovlan    = '1;
            c.ovlan_ok = 1'b1;
        end
        if (s[SB_PF]) c.pf = '1;
        if (s[SB_VF]) c.vf = '1;
        if (s[SB_PF] || s[SB_VF]) c.fn_ok = 1'b1;
        return c;
    endfunction

    // Full participation mask: flow fields always, compact by selection.
    function automatic key_t care_mask(logic [SEL_W-1:0] s);
        key_t k;
        k.lip   = '1;
        k.fip   = '1;
        k.lport = '1;
        k.fport = '1;
        k.c     = sel_mask(s);
        return k;
    endfunction

endpackage

// File: rtl/pkt_flt_sel_reg.sv
module pkt_flt_sel_reg
    import pkt_flt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_data,
    output logic [SEL_W-1:0] sel_q
);

    logic fits;

    assign fits = (sel_width(wr_data) <= CAP_BITS);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else if (wr_en && fits) begin
            sel_q <= wr_data;
        end
    end

endmodule

// File: rtl/pkt_flt_rule_store.sv
module pkt_flt_rule_store
    import pkt_flt_pkg::*;
#(
    parameter int N_ENT = 16,
    parameter int IDX_W = $clog2(N_ENT)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic                   wr_del,
    input  logic [IDX_W-1:0]       wr_idx,
    input  rule_t                  wr_rule,
    output rule_t [N_ENT-1:0]      ents
);

    logic load_ok;

    assign load_ok = (wr_rule.act != ACT_RSVD);

    always_ff @(posedge clk) begin
        if (rst) begin
            ents <= '0;
        end else if (wr_en) begin
            for (int e = 0; e < N_ENT; e++) begin
                if (wr_idx == IDX_W'(e)) begin
                    if (wr_del) begin
                        ents[e].vld <= 1'b0;
                    end else if (load_ok) begin
                        ents[e] <= wr_rule;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/pkt_flt_match.sv
module pkt_flt_match
    import pkt_flt_pkg::*;
(
    input  rule_t rule,
    input  key_t  pkt,
    input  logic  v6,
    input  key_t  care,
    output logic  hit
);

    logic [KEY_W-1:0] p_vec;
    logic [KEY_W-1:0] m_vec;
    logic [KEY_W-1:0] v_vec;
    logic [KEY_W-1:0] c_vec;
    logic [KEY_W-1:0] diff;

    assign p_vec = pkt;
    assign m_vec = rule.msk;
    assign v_vec = rule.val;
    assign c_vec = care;
    assign diff  = ((p_vec & m_vec) ^ v_vec) & c_vec;

    assign hit = rule.vld && (rule.v6 == v6) && (diff == '0);

endmodule

// File: rtl/pkt_flt_prio.sv
module pkt_flt_prio #(
    parameter int N_ENT = 16,
    parameter int IDX_W = $clog2(N_ENT)
) (
    input  logic [N_ENT-1:0] req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    assign any = |req;

    always_comb begin
        idx = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/pkt_flt_table.sv
module pkt_flt_table
    import pkt_flt_pkg::*;
#(
    parameter  int N_ENT = 16,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_wr_en,
    input  logic [SEL_W-1:0] sel_wr_data,
    input  logic             wr_en,
    input  logic             wr_del,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_v6,
    input  logic [KEY_W-1:0] wr_val,
    input  logic [KEY_W-1:0] wr_msk,
    input  logic [1:0]       wr_action,
    input  logic             wr_steer,
    input  logic [QID_W-1:0] wr_queue,
    input  logic             lk_valid,
    input  logic             lk_v6,
    input  logic [KEY_W-1:0] lk_key,
    output logic             res_valid,
    output logic             res_hit,
    output logic [IDX_W-1:0] res_idx,
    output logic [1:0]       res_action,
    output logic             res_steer,
    output logic [QID_W-1:0] res_queue
);

    logic [SEL_W-1:0]  sel_q;
    key_t              care;
    key_t              pkt;
    rule_t             new_rule;
    rule_t [N_ENT-1:0] ents;
    logic  [N_ENT-1:0] hits;
    logic              any_hit;
    logic [IDX_W-1:0]  win;
    rule_t             win_rule;

    pkt_flt_sel_reg u_sel (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (sel_wr_en),
        .wr_data (sel_wr_data),
        .sel_q   (sel_q)
    );

    assign care = care_mask(sel_q);
    assign pkt  = key_t'(lk_key);

    always_comb begin
        new_rule       = '0;
        new_rule.vld   = 1'b1;
        new_rule.v6    = wr_v6;
        new_rule.val   = key_t'(wr_val);
        new_rule.msk   = key_t'(wr_msk);
        new_rule.act   = act_e'(wr_action);
        new_rule.steer = wr_steer;
        new_rule.queue = wr_queue;
    end

    pkt_flt_rule_store #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_del  (wr_del),
        .wr_idx  (wr_idx),
        .wr_rule (new_rule),
        .ents    (ents)
    );

    for (genvar e = 0; e < N_ENT; e++) begin : g_cmp
        pkt_flt_match u_match (
            .rule (ents[e]),
            .pkt  (pkt),
            .v6   (lk_v6),
            .care (care),
            .hit  (hits[e])
        );
    end

    pkt_flt_prio #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_prio (
        .req (hits),
        .any (any_hit),
        .idx (win)
    );

    assign win_rule = ents[win];

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid  <= 1'b0;
            res_hit    <= 1'b0;
            res_idx    <= '0;
            res_action <= ACT_PASS;
            res_steer  <= 1'b0;
            res_queue  <= '0;
        end else begin
            res_valid <= lk_valid;
            if (lk_valid && any_hit) begin
                res_hit    <= 1'b1;
                res_idx    <= win;
                res_action <= win_rule.act;
                res_steer  <= win_rule.steer;
                res_queue  <= win_rule.steer ? win_rule.queue : '0;
            end else begin
                res_hit    <= 1'b0;
                res_idx    <= '0;
                res_action <= ACT_PASS;
                res_steer  <= 1'b0;
                res_queue  <= '0;
            end
        end
    end

endmodule

// File: rtl/pkt_flt_chk.sv
module pkt_flt_chk
    import pkt_flt_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             lk_valid,
    input logic             res_valid,
    input logic             res_hit,
    input logic [IDX_W-1:0] res_idx,
    input logic [1:0]       res_action,
    input logic             res_steer,
    input logic [QID_W-1:0] res_queue,
    input logic [SEL_W-1:0] sel_q
);

    // R7
    res_valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> res_valid);

    // R7
    res_idle_follows_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !res_valid);

    // R7
    no_hit_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> !res_hit);

    // R6
    miss_defaults_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_hit) |->
            (res_action == 2'd0 && !res_steer && res_queue == '0 && res_idx == '0));

    // R10
    no_rsvd_action_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_action != 2'd3));

    // R11
    hash_queue_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !res_steer |-> (res_queue == '0));

    // R4
    sel_cap_chk: assert property (@(posedge clk) disable iff (rst)
        sel_width(sel_q) <= CAP_BITS);

endmodule

bind pkt_flt_table pkt_flt_chk #(.IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .lk_valid   (lk_valid),
    .res_valid  (res_valid),
    .res_hit    (res_hit),
    .res_idx    (res_idx),
    .res_action (res_action),
    .res_steer  (res_steer),
    .res_queue  (res_queue),
    .sel_q      (sel_q)
);

// File: tb/pkt_flt_table_bench.sv
module pkt_flt_table_bench;
    import pkt_flt_pkg::*;

    localparam int N = 16;
    localparam int IW = $clog2(N);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             sel_wr_en = 1'b0;
    logic [SEL_W-1:0] sel_wr_data = '0;
    logic             wr_en = 1'b0;
    logic             wr_del = 1'b0;
    logic [IW-1:0]    wr_idx = '0;
    logic             wr_v6 = 1'b0;
    logic [KEY_W-1:0] wr_val = '0;
    logic [KEY_W-1:0] wr_msk = '0;
    logic [1:0]       wr_action = '0;
    logic             wr_steer = 1'b0;
    logic [QID_W-1:0] wr_queue = '0;
    logic             lk_valid = 1'b0;
    logic             lk_v6 = 1'b0;
    logic [KEY_W-1:0] lk_key = '0;
    logic             res_valid;
    logic             res_hit;
    logic [IW-1:0]    res_idx;
    logic [1:0]       res_action;
    logic             res_steer;
    logic [QID_W-1:0] res_queue;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pkt_flt_table #(.N_ENT(N)) u_pkt_flt_table (
        .clk(clk), .rst(rst),
        .sel_wr_en(sel_wr_en), .sel_wr_data(sel_wr_data),
        .wr_en(wr_en), .wr_del(wr_del), .wr_idx(wr_idx), .wr_v6(wr_v6),
        .wr_val(wr_val), .wr_msk(wr_msk), .wr_action(wr_action),
        .wr_steer(wr_steer), .wr_queue(wr_queue),
        .lk_valid(lk_valid), .lk_v6(lk_v6), .lk_key(lk_key),
        .res_valid(res_valid), .res_hit(res_hit), .res_idx(res_idx),
        .res_action(res_action), .res_steer(res_steer), .res_queue(res_queue)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic put_rule(input int idx, input logic v6, input key_t v, input key_t m,
                            input int act, input logic st, input int q);
        @(negedge clk);
        wr_en = 1'b1; wr_del = 1'b0; wr_idx = IW'(idx); wr_v6 = v6;
        wr_val = v; wr_msk = m; wr_action = 2'(act); wr_steer = st; wr_queue = QID_W'(q);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic del_rule(input int idx);
        @(negedge clk);
        wr_en = 1'b1; wr_del = 1'b1; wr_idx = IW'(idx);
        @(negedge clk);
        wr_en = 1'b0; wr_del = 1'b0;
    endtask

    task automatic put_sel(input int s);
        @(negedge clk);
        sel_wr_en = 1'b1; sel_wr_data = SEL_W'(s);
        @(negedge clk);
        sel_wr_en = 1'b0;
    endtask

    task automatic look(input key_t k, input logic v6);
        @(negedge clk);
        lk_valid = 1'b1; lk_key = k; lk_v6 = v6;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic expect_res(input string req, input logic hit, input int idx,
                              input int act, input logic st, input int q);
        chk({req, " valid"}, int'(res_valid), 1);
        chk({req, " hit"}, int'(res_hit), int'(hit));
        chk({req, " idx"}, int'(res_idx), hit ? idx : 0);
        chk({req, " action"}, int'(res_action), hit ? act : 0);
        chk({req, " steer"}, int'(res_steer), hit ? int'(st) : 0);
        chk({req, " queue"}, int'(res_queue), (hit && st) ? q : 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        key_t k;
        key_t z;
        key_t m;
        z = '0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R12 reset state and empty table
        chk("R12 reset res_valid", int'(res_valid), 0);
        chk("R12 reset res_hit", int'(res_hit), 0);
        look(z, 1'b0);
        expect_res("R12 R6 empty miss", 1'b0, 0, 0, 1'b0, 0);
        chk("R7 idle after lookup", int'(res_valid), 1);
        @(negedge clk);
        chk("R7 res_valid drops", int'(res_valid), 0);
        chk("R7 hit low idle", int'(res_hit), 0);

        // R1 R8 R11 exact local-port rules at every slot
        for (int i = 0; i < N; i++) begin
            k = '0; k.lport = PORT_W'(i * 3 + 1);
            m = '0; m.lport = '1;
            put_rule(i, 1'b0, k, m, i % 3, i[0], i * 37 + 5);
        end
        for (int i = 0; i < N; i++) begin
            k = '0; k.lport = PORT_W'(i * 3 + 1); k.fip = 128'hdead;
            look(k, 1'b0);
            expect_res("R1 R11 slot sweep", 1'b1, i, i % 3, i[0], i * 37 + 5);
        end
        k = '0; k.lport = 16'd100;
        look(k, 1'b0);
        expect_res("R1 R6 no lport match", 1'b0, 0, 0, 1'b0, 0);

        // R5 R9 wildcard everywhere, delete from the bottom up
        for (int i = 0; i < N; i++) put_rule(i, 1'b0, z, z, 1, 1'b0, 0);
        for (int d = 0; d < N; d++) begin
            k = '0; k.lip = 128'(d * 1000 + 7);
            look(k, 1'b0);
            expect_res("R5 lowest wins", 1'b1, d, 1, 1'b0, 0);
            del_rule(d);
        end
        look(z, 1'b0);
        expect_res("R9 all deleted", 1'b0, 0, 0, 1'b0, 0);

        // R1 partial mask sweep on slot 3
        k = '0; k.lport = 16'h0030;
        m = '0; m.lport = 16'h00f0;
        put_rule(3, 1'b0, k, m, 2, 1'b0, 0);
        for (int p = 0; p < 256; p++) begin
            k = '0; k.lport = PORT_W'(p);
            look(k, 1'b0);
            expect_res("R1 partial mask", ((p & 8'hf0) == 8'h30), 3, 2, 1'b0, 0);
        end

        // R2 family bit
        put_rule(3, 1'b1, z, z, 1, 1'b1, 9);
        look(z, 1'b0);
        expect_res("R2 v4 vs v6 rule", 1'b0, 0, 0, 1'b0, 0);
        look(z, 1'b1);
        expect_res("R2 v6 vs v6 rule", 1'b1, 3, 1, 1'b1, 9);

        // R3 R4 select register with ingress-port rule on slot 5
        k = '0; k.c.iport = 3'd5;
        m = '0; m.c.iport = 3'd7;
        put_rule(5, 1'b0, k, m, 1, 1'b0, 0);
        k = '0; k.c.iport = 3'd4;
        look(k, 1'b0);
        expect_res("R3 R12 unselected field ignored", 1'b1, 5, 1, 1'b0, 0);
        put_sel(1 << SB_IPORT);
        look(k, 1'b0);
        expect_res("R3 selected field mismatch", 1'b0, 0, 0, 1'b0, 0);
        k.c.iport = 3'd5;
        look(k, 1'b0);
        expect_res("R3 selected field match", 1'b1, 5, 1, 1'b0, 0);
        put_sel((1 << SB_ETH) | (1 << SB_IVLAN) | (1 << SB_OVLAN));
        k.c.iport = 3'd4;
        look(k, 1'b0);
        expect_res("R4 48-bit select rejected", 1'b0, 0, 0, 1'b0, 0);
        put_sel((1 << SB_ETH) | (1 << SB_IVLAN) | (1 << SB_FRAG));
        look(k, 1'b0);
        expect_res("R4 33-bit select accepted", 1'b1, 5, 1, 1'b0, 0);
        put_sel((1 << SB_ETH) | (1 << SB_IVLAN) | (1 << SB_FRAG) | (1 << SB_IPORT));
        look(k, 1'b0);
        expect_res("R4 36-bit select accepted", 1'b0, 0, 0, 1'b0, 0);
        put_sel((1 << SB_ETH) | (1 << SB_IVLAN) | (1 << SB_PROTO));
        look(k, 1'b0);
        expect_res("R4 40-bit select rejected", 1'b0, 0, 0, 1'b0, 0);

        // R10 reserved action write ignored
        k = '0; k.c.iport = 3'd4;
        m = '0; m.c.iport = 3'd7;
        put_rule(5, 1'b0, k, m, 3, 1'b1, 77);
        look(k, 1'b0);
        expect_res("R10 reserved write no new match", 1'b0, 0, 0, 1'b0, 0);
        k.c.iport = 3'd5;
        look(k, 1'b0);
        expect_res("R10 old rule kept", 1'b1, 5, 1, 1'b0, 0);

        // R8 write and lookup in the same cycle
        m = '0; m.c.iport = 3'd7;
        @(negedge clk);
        wr_en = 1'b1; wr_del = 1'b0; wr_idx = IW'(5); wr_v6 = 1'b0;
        wr_val = k; wr_msk = m; wr_action = 2'd2; wr_steer = 1'b1; wr_queue = 10'h155;
        lk_valid = 1'b1; lk_key = k; lk_v6 = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
        expect_res("R8 same-cycle sees old", 1'b1, 5, 1, 1'b0, 0);
        @(negedge clk);
        lk_valid = 1'b0;
        expect_res("R8 R11 next cycle sees new", 1'b1, 5, 2, 1'b1, 10'h155);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule